// File: doc/BRIEF.md
# Header Length Tracking Extraction Unit

This unit sits in the front of a streaming packet parser. Each cycle it may accept one 64-bit packet word. With that word it receives the control fields of the current parse instruction, one per extraction engine. Three engines run in parallel. Each one cuts a small field out of the word at a programmable bit offset and width, then routes it to a destination chosen by the instruction.

Fields that carry lengths are converted to bytes as they are captured. A header length counted in 32-bit words is multiplied by four. A packet length already given in bytes is loaded as it is. A combined type-or-length field is compared against 1500. Above that value it is kept as a next-protocol code. At 1500 or below it is loaded into the packet byte counter.

Both byte counters then count down by eight for every word that arrives, with no further instruction. They report "done" and "last partial word" flags that branch logic can test. A start-of-packet pulse or the synchronous reset clears everything.

Top module: `hdr_len_tracker`

## Requirements
- R1: A field is taken from the word starting at bit `off` (bit 0 = LSB of `data`). Its width comes from the 2-bit code: 0 gives 8 bits, 1 gives 16, 2 gives 32, 3 gives 4. Bits above bit 63 read as zero. Engine e uses `eng_ctl[11e+10]` as enable, `[11e+9:11e+8]` as destination, `[11e+7:11e+6]` as width code and `[11e+5:11e]` as offset. Destination 3 copies the field into `aux_val`.
- R2: Destination 0 loads `hdr_rem` with the low 16 bits of the field times 4, because the field counts 32-bit words.
- R3: Destination 1 loads `pkt_rem` with the low 16 bits of the field, which are already in bytes.
- R4: Destination 2 puts the low 16 bits into `proto_code` and sets `proto_vld` when the value is greater than 1500. Otherwise the value is loaded into `pkt_rem`.
- R5: A valid word that does not load a counter decrements that counter by 8, saturating at 0. When `vld` is low, all state holds and no engine extracts.
- R6: `hdr_done` (`pkt_done`) is high when its counter has been loaded since the last clear and now reads 0. After a 4-bit header length of 5 is captured, `hdr_done` rises after the third following valid word.
- R7: `hdr_part` (`pkt_part`) is high when its counter has been loaded and holds a value from 1 to 7.
- R8: When two engines load the same register in one word, the lowest-numbered engine wins. A load takes precedence over that cycle's decrement.
- R9: `rst` or `sop` clears every counter, loaded mark and captured register on the next edge. The word presented with `sop` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sop | input | 1 | Start of packet, clears state, word ignored |
| vld | input | 1 | Data word and control valid |
| data | input | 64 | Packet data word |
| eng_ctl | input | 33 | Three 11-bit engine control fields |
| hdr_rem | output | 18 | Header bytes remaining |
| pkt_rem | output | 18 | Packet/payload bytes remaining |
| hdr_done | output | 1 | Header counter loaded and exhausted |
| hdr_part | output | 1 | Header counter between 1 and 7 |
| pkt_done | output | 1 | Packet counter loaded and exhausted |
| pkt_part | output | 1 | Packet counter between 1 and 7 |
| proto_vld | output | 1 | Next-protocol code captured |
| proto_code | output | 16 | Captured next-protocol code |
| aux_val | output | 32 | Raw field for destination 3 |

## Verification
The hardest case to reach from the ports is contention in a single word. Here two or three engines aim at the same counter, and a type-or-length field may land in the packet counter at the same moment as a byte-length field from another engine. A decrement is pending in that same cycle. Directed words set up each pairing with explicit engine order. This includes the 1500/1501 boundary on either side of a competing load. A long stretch of random control words with occasional start-of-packet pulses then covers the remaining collisions. The behavioural model is compared against the outputs every cycle.

// File: rtl/hdr_len_tracker.sv
module hdr_len_tracker #(
  parameter int DW      = 64,
  parameter int NENG    = 3,
  parameter int CW      = 18,
  parameter int LEN_MAX = 1500
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sop,
  input  logic                 vld,
  input  logic [DW-1:0]        data,
  input  logic [NENG*(5+$clog2(DW))-1:0] eng_ctl,
  output logic [CW-1:0]        hdr_rem,
  output logic [CW-1:0]        pkt_rem,
  output logic                 hdr_done,
  output logic                 hdr_part,
  output logic                 pkt_done,
  output logic                 pkt_part,
  output logic                 proto_vld,
  output logic [15:0]          proto_code,
  output logic [31:0]          aux_val
);
  localparam int OFFW = $clog2(DW);
  localparam int EF   = OFFW + 5;
  localparam logic [CW-1:0] BPW  = CW'(DW / 8);
  localparam logic [15:0]   LMAX = 16'(LEN_MAX);

  logic [31:0] fval  [NENG];
  logic        en_w  [NENG];
  logic [1:0]  dst_w [NENG];

  for (genvar e = 0; e < NENG; e++) begin : g_eng
    logic [EF-1:0] c;
    logic [DW-1:0] sh;
    assign c        = eng_ctl[e*EF +: EF];
    assign en_w[e]  = c[EF-1];
    assign dst_w[e] = c[EF-2 -: 2];
    assign sh       = data >> c[OFFW-1:0];
    always_comb begin
      case (c[OFFW+1:OFFW])
        2'd0:    fval[e] = {24'b0, sh[7:0]};
        2'd1:    fval[e] = {16'b0, sh[15:0]};
        2'd2:    fval[e] = sh[31:0];
        default: fval[e] = {28'b0, sh[3:0]};
      endcase
    end
  end

  logic h_ld, p_ld, c_ld, x_ld;
  logic [CW-1:0] h_val, p_val;
  logic [15:0]   c_val;
  logic [31:0]   x_val;

  always_comb begin
    h_ld = 1'b0; p_ld = 1'b0; c_ld = 1'b0; x_ld = 1'b0;
    h_val = '0; p_val = '0; c_val = '0; x_val = '0;
    for (int e = NENG - 1; e >= 0; e--) begin
      if (vld && en_w[e]) begin
        case (dst_w[e])
          2'd0: begin h_ld = 1'b1; h_val = CW'({fval[e][15:0], 2'b00}); end
          2'd1: begin p_ld = 1'b1; p_val = CW'(fval[e][15:0]); end
          2'd2: begin
            if (fval[e][15:0] > LMAX) begin c_ld = 1'b1; c_val = fval[e][15:0]; end
            else begin p_ld = 1'b1; p_val = CW'(fval[e][15:0]); end
          end
          default: begin x_ld = 1'b1; x_val = fval[e]; end
        endcase
      end
    end
  end

  logic hdr_arm, pkt_arm;

  always_ff @(posedge clk) begin
    if (rst || sop) begin
      hdr_rem <= '0; pkt_rem <= '0; hdr_arm <= 1'b0; pkt_arm <= 1'b0;
      proto_vld <= 1'b0; proto_code <= '0; aux_val <= '0;
    end else if (vld) begin
      if (h_ld) begin hdr_rem <= h_val; hdr_arm <= 1'b1; end
      else hdr_rem <= (hdr_rem > BPW) ? hdr_rem - BPW : '0;
      if (p_ld) begin pkt_rem <= p_val; pkt_arm <= 1'b1; end
      else pkt_rem <= (pkt_rem > BPW) ? pkt_rem - BPW : '0;
      if (c_ld) begin proto_code <= c_val; proto_vld <= 1'b1; end
      if (x_ld) aux_val <= x_val;
    end
  end

  assign hdr_done = hdr_arm && (hdr_rem == '0);
  assign pkt_done = pkt_arm && (pkt_rem == '0);
  assign hdr_part = hdr_arm && (hdr_rem != '0) && (hdr_rem < BPW);
  assign pkt_part = pkt_arm && (pkt_rem != '0) && (pkt_rem < BPW);

  AST_CLEAR_ON_SOP: assert property (@(posedge clk) disable iff (rst) sop |=> (hdr_rem == '0 && pkt_rem == '0 && !proto_vld && !hdr_done)); // R9
  AST_HDR_NO_RISE: assert property (@(posedge clk) disable iff (rst) (!sop && !h_ld) |=> hdr_rem <= $past(hdr_rem)); // R5
  AST_PKT_STEP: assert property (@(posedge clk) disable iff (rst) (!sop && vld && !p_ld) |=> ($past(pkt_rem) - pkt_rem) <= BPW); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!sop && !vld) |=> ($stable(hdr_rem) && $stable(pkt_rem) && $stable(proto_code))); // R5
  AST_PROTO_RANGE: assert property (@(posedge clk) disable iff (rst) proto_vld |-> proto_code > LMAX); // R4
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) (hdr_done && !sop && !h_ld) |=> hdr_done); // R6
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(hdr_done && hdr_part) && !(pkt_done && pkt_part)); // R7
endmodule

// File: tb/hdr_len_tracker_tb.sv
module hdr_len_tracker_tb_top;
  localparam int PER = 10;
  logic clk = 1'b0, rst = 1'b1, sop = 1'b0, vld = 1'b0;
  logic [63:0] data = '0;
  logic [32:0] eng_ctl = '0;
  logic [17:0] hdr_rem, pkt_rem;
  logic hdr_done, hdr_part, pkt_done, pkt_part, proto_vld;
  logic [15:0] proto_code;
  logic [31:0] aux_val;
  int n_cmp = 0, n_bad = 0;

  always #(PER/2) clk = ~clk;

  hdr_len_tracker dut_i (.clk(clk), .rst(rst), .sop(sop), .vld(vld), .data(data),
    .eng_ctl(eng_ctl), .hdr_rem(hdr_rem), .pkt_rem(pkt_rem), .hdr_done(hdr_done),
    .hdr_part(hdr_part), .pkt_done(pkt_done), .pkt_part(pkt_part),
    .proto_vld(proto_vld), .proto_code(proto_code), .aux_val(aux_val));

  int m_hr, m_pr, m_pc;
  bit m_ha, m_pa, m_pv;
  longint m_aux;

  function automatic logic [10:0] ec(bit en, int dst, int wc, int off);
    return {en, 2'(dst), 2'(wc), 6'(off)};
  endfunction

  function automatic longint field(logic [63:0] d, logic [10:0] c);
    logic [63:0] s;
    s = d >> c[5:0];
    case (c[7:6])
      2'd0: return longint'(s % 256);
      2'd1: return longint'(s % 65536);
      2'd2: return longint'(s % 64'h1_0000_0000);
      default: return longint'(s % 16);
    endcase
  endfunction

  task automatic model(bit r, bit s, bit v, logic [63:0] d, logic [32:0] c);
    bit hl = 0, pl = 0; int hv = 0, pv = 0;
    if (r || s) begin
      m_hr = 0; m_pr = 0; m_ha = 0; m_pa = 0; m_pv = 0; m_pc = 0; m_aux = 0;
      return;
    end
    if (!v) return;
    for (int e = 2; e >= 0; e--) begin
      logic [10:0] c1; longint f;
      c1 = c[e*11 +: 11];
      if (c1[10]) begin
        f = field(d, c1);
        case (c1[9:8])
          2'd0: begin hl = 1; hv = int'(f % 65536) * 4; end
          2'd1: begin pl = 1; pv = int'(f % 65536); end
          2'd2: if (f % 65536 > 1500) begin m_pv = 1; m_pc = int'(f % 65536); end
                else begin pl = 1; pv = int'(f % 65536); end
          default: m_aux = f;
        endcase
      end
    end
    if (hl) begin m_hr = hv; m_ha = 1; end else m_hr = (m_hr > 8) ? m_hr - 8 : 0;
    if (pl) begin m_pr = pv; m_pa = 1; end else m_pr = (m_pr > 8) ? m_pr - 8 : 0;
  endtask

  task automatic chk(string req, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2/R5 hdr_rem", hdr_rem, m_hr);
    chk("R3/R5 pkt_rem", pkt_rem, m_pr);
    chk("R6 hdr_done", hdr_done, m_ha && m_hr == 0);
    chk("R6 pkt_done", pkt_done, m_pa && m_pr == 0);
    chk("R7 hdr_part", hdr_part, m_ha && m_hr > 0 && m_hr < 8);
    chk("R7 pkt_part", pkt_part, m_pa && m_pr > 0 && m_pr < 8);
    chk("R4 proto_vld", proto_vld, m_pv);
    chk("R4 proto_code", proto_code, m_pc);
    chk("R1 aux_val", aux_val, m_aux);
  endtask

  task automatic cyc(bit s, bit v, logic [63:0] d, logic [32:0] c);
    sop = s; vld = v; data = d; eng_ctl = c;
    model(rst, s, v, d, c);
    @(posedge clk); #1;
    compare_all();
  endtask

  initial begin
    #(PER * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    cyc(0, 0, '0, '0);
    cyc(0, 1, '1, {3{ec(1, 1, 1, 0)}});
    rst = 1'b0;
    cyc(0, 0, '0, '0);                                   // reset state
    // R6: header length 5 in a nibble -> 20 bytes, done after third word
    cyc(0, 1, 64'h45, {22'b0, ec(1, 0, 3, 0)});
    cyc(0, 1, '1, '0);
    cyc(0, 1, '1, '0);                                   // R7 4 left
    cyc(0, 1, '1, '0);
    cyc(0, 1, '1, '0);
    // R4: protocol code above the limit
    cyc(0, 1, 64'h0800 << 16, {11'b0, ec(1, 2, 1, 16), 11'b0});
    // R4 boundary: 1500 is a length, 1501 a code
    cyc(0, 1, 64'd1500 << 32, {ec(1, 2, 1, 32), 22'b0});
    cyc(0, 1, 64'd1501 << 32, {ec(1, 2, 1, 32), 22'b0});
    // R3 byte length then countdown and saturation (R5)
    cyc(0, 1, 64'd19 << 48, {22'b0, ec(1, 1, 1, 48)});
    for (int i = 0; i < 4; i++) cyc(0, 1, '0, '0);
    // R5: idle cycles with engines enabled change nothing
    cyc(0, 1, 64'd30, {22'b0, ec(1, 1, 0, 0)});
    cyc(0, 0, 64'd99, {3{ec(1, 1, 0, 0)}});
    cyc(0, 0, 64'd99, {3{ec(1, 0, 0, 0)}});
    // R8: engine 0 beats engine 1 on the packet counter
    cyc(0, 1, 64'h00C8_000A, {11'b0, ec(1, 1, 1, 16), ec(1, 1, 1, 0)});
    // R8: engine 0 length via dst2 beats engine 2 via dst1
    cyc(0, 1, 64'h0050_0000_012C, {ec(1, 1, 1, 32), 11'b0, ec(1, 2, 1, 0)});
    // R1: offset near the top, upper bits read zero; 32-bit raw field
    cyc(0, 1, 64'hABCD_0000_0000_0000, {22'b0, ec(1, 3, 1, 60)});
    cyc(0, 1, 64'h1234_5678_9ABC_DEF0, {ec(1, 3, 2, 12), 22'b0});
    cyc(0, 1, 64'h1234_5678_9ABC_DEF0, {11'b0, ec(1, 3, 0, 4), 11'b0});
    // R9: start of packet clears and ignores its word
    cyc(1, 1, 64'hFFFF, {3{ec(1, 1, 1, 0)}});
    cyc(0, 0, '0, '0);
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] d; logic [32:0] c;
      d = {$urandom, $urandom};
      if (i % 3 == 0) d = d & 64'h0000_07FF_07FF_07FF;
      c = {$urandom, $urandom} % (64'd1 << 33);
      cyc(($urandom % 40) == 0, ($urandom % 5) != 0, d, c);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule